// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block drives a video panel with horizontal sync, vertical sync, a data-enable strobe and a per-pixel colour. Software programs the timing through a simple write port: a line period with its sync width, a frame period and vertical sync width both counted in pixel clocks, a display window, an optional active sub-window, a line-start skew, two fill colours, output polarity and an engine enable. Vertical position comes from a single frame-wide pixel counter rather than from a line counter, so every vertical boundary is an absolute pixel-clock position within the frame.

Inside the display window, pixels that fall outside an enabled active sub-window are shown in a border colour. Inside the active region, the pixel word from the fetch side is passed through when it is valid. When it is not valid, an underflow colour replaces it and an underrun pulse is raised. A one-cycle frame-start pulse serves as the frame interrupt source. Settings written while the engine runs are held in a pending copy and only reach the working copy at the next frame boundary.

Top module: `vid_timing_gen`

## Requirements
- R1: Address 0 holds the line period in bits 31:16 and the hsync width in bits 15:0. The horizontal position counts 0 to period-1, and hsync is asserted while the position is below the width.
- R2: Address 1 holds the frame period and address 2 the vsync width, both in pixel clocks (bits 23:0). The frame counter counts 0 to period-1, and vsync is asserted while it is below the width.
- R3: Address 3 holds the display end x in bits 31:16 and the start x in bits 15:0. Addresses 4 and 5 hold the display start and end frame positions (bits 23:0, inclusive). Data enable is asserted only when both the x and the frame position lie inside these bounds.
- R4: Address 11 holds a skew (bits 15:0). Lines begin at frame positions skew + k*period, so the horizontal position at frame position 0 is period-skew, or 0 when the skew is 0.
- R5: Address 6 holds the active-window enable in bit 31, the end x in bits 30:16 and the start x in bits 15:0. Address 7 holds the vertical enable in bit 31 and the start in bits 23:0, and address 8 holds the end. A dimension whose enable is clear counts as fully active. Inside the display window but outside the active region, the colour is the border colour from address 9 (bits 23:0).
- R6: Inside the active region, a valid pixel word is output unchanged. An invalid one is replaced by the underflow colour from address 10 (bits 23:0), and the underrun output pulses for that pixel.
- R7: Address 12 bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data enable. Zero means active-high.
- R8: All video outputs are registered and appear one clock after the counter position and pixel input they describe. The colour is 0 outside the display window.
- R9: The frame-start output pulses for the one pixel at frame position 0 of every frame while the engine runs.
- R10: Address 13 bit 0 enables the line-number output and bit 1 enables the completed-frame count output. A disabled output reads 0. The line number resets at each frame start and increments at each line wrap.
- R11: Address 14 bit 0 is the engine enable. Writing 0 stops the counters at frame position 0 and drives every sync and enable output at its inactive level. Writing 1 starts the engine at frame position 0.
- R12: Timing, colour and polarity writes made while the engine runs take effect only at the next frame boundary. While the engine is stopped, they take effect one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 32 | Register write data |
| pixValid | input | 1 | Pixel word is available this clock |
| pixIn | input | 24 | Pixel word from the fetch side |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pixOut | output | 24 | Selected output colour |
| vsStart | output | 1 | One-clock frame-start pulse |
| underrun | output | 1 | One-clock missing-pixel pulse |
| lineCount | output | 16 | Current line number within the frame |
| frameCount | output | 16 | Frames completed since the engine started |

## Verification
The hardest case to reach from the ports is a write that lands mid-frame, because its effect must stay hidden until the frame counter wraps. The fault shows only as a wrong sync width or polarity on pixels near the next boundary. The stimulus changes the sync width and polarity partway through a frame, and later changes skew, windows and colours the same way. A behavioural model tracks the pending and working copies separately and compares every output on every clock, so any early or late switch is caught at the exact pixel. Random pixel-valid gaps inside an enabled active sub-window drive the underflow path, and a stop with all polarities inverted checks the inactive levels.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int H_W   = 16;
  localparam int FC_W  = 24;
  localparam int COL_W = 24;
  localparam int FN_W  = 16;
  localparam int AW    = 4;

  typedef enum logic [AW-1:0] {
    A_HCTL   = 4'd0,
    A_FPER   = 4'd1,
    A_VSW    = 4'd2,
    A_DISPH  = 4'd3,
    A_DISPVS = 4'd4,
    A_DISPVE = 4'd5,
    A_ACTH   = 4'd6,
    A_ACTVS  = 4'd7,
    A_ACTVE  = 4'd8,
    A_BORDER = 4'd9,
    A_UFLOW  = 4'd10,
    A_SKEW   = 4'd11,
    A_POL    = 4'd12,
    A_CNTEN  = 4'd13,
    A_ENGINE = 4'd14
  } vtg_addr_e;

  typedef struct packed {
    logic [H_W-1:0]   hPeriod;
    logic [H_W-1:0]   hsWidth;
    logic [FC_W-1:0]  fPeriod;
    logic [FC_W-1:0]  vsWidth;
    logic [H_W-1:0]   dhStart;
    logic [H_W-1:0]   dhEnd;
    logic [FC_W-1:0]  dvStart;
    logic [FC_W-1:0]  dvEnd;
    logic             ahEn;
    logic [H_W-1:0]   ahStart;
    logic [H_W-1:0]   ahEnd;
    logic             avEn;
    logic [FC_W-1:0]  avStart;
    logic [FC_W-1:0]  avEnd;
    logic [COL_W-1:0] border;
    logic [COL_W-1:0] uflow;
    logic [H_W-1:0]   skew;
    logic [2:0]       pol;
  } vtg_cfg_t;

  typedef struct packed {
    logic run;
    logic hsOn;
    logic vsOn;
    logic dispOn;
    logic actOn;
    logic frameStart;
  } vtg_strobe_t;
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [31:0]       wrData,
  output vtg_strobe_t       strobe,
  output logic [2:0]        pol,
  output logic [COL_W-1:0]  border,
  output logic [COL_W-1:0]  uflow,
  output logic [H_W-1:0]    lineCount,
  output logic [FN_W-1:0]   frameCount
);
  vtg_cfg_t        pend, live;
  logic            run;
  logic [1:0]      cntEn;
  logic [FC_W-1:0] fc;
  logic [H_W-1:0]  x, lineNo;
  logic [FN_W-1:0] frames;
  logic            frameEnd, lineEnd;
  logic            inDispH, inDispV, inActH, inActV;

  function automatic logic [H_W-1:0] initX(vtg_cfg_t c);
    return (c.skew == '0) ? '0 : H_W'(c.hPeriod - c.skew);
  endfunction

  // pending copy and immediate controls
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend  <= '0;
      run   <= 1'b0;
      cntEn <= '0;
    end else if (wrEn) begin
      case (vtg_addr_e'(wrAddr))
        A_HCTL:   begin pend.hPeriod <= wrData[31:16]; pend.hsWidth <= wrData[15:0]; end
        A_FPER:   pend.fPeriod <= wrData[FC_W-1:0];
        A_VSW:    pend.vsWidth <= wrData[FC_W-1:0];
        A_DISPH:  begin pend.dhEnd <= wrData[31:16]; pend.dhStart <= wrData[15:0]; end
        A_DISPVS: pend.dvStart <= wrData[FC_W-1:0];
        A_DISPVE: pend.dvEnd <= wrData[FC_W-1:0];
        A_ACTH:   begin
          pend.ahEn    <= wrData[31];
          pend.ahEnd   <= {1'b0, wrData[30:16]};
          pend.ahStart <= wrData[15:0];
        end
        A_ACTVS:  begin pend.avEn <= wrData[31]; pend.avStart <= wrData[FC_W-1:0]; end
        A_ACTVE:  pend.avEnd <= wrData[FC_W-1:0];
        A_BORDER: pend.border <= wrData[COL_W-1:0];
        A_UFLOW:  pend.uflow <= wrData[COL_W-1:0];
        A_SKEW:   pend.skew <= wrData[H_W-1:0];
        A_POL:    pend.pol <= wrData[2:0];
        A_CNTEN:  cntEn <= wrData[1:0];
        A_ENGINE: run <= wrData[0];
        default:  ;
      endcase
    end
  end

  assign frameEnd = (fc == FC_W'(live.fPeriod - 1'b1));
  assign lineEnd  = (x == H_W'(live.hPeriod - 1'b1));

  // frame and line counters, working copy loaded at frame boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      live   <= '0;
      fc     <= '0;
      x      <= '0;
      lineNo <= '0;
      frames <= '0;
    end else if (!run) begin
      live   <= pend;
      fc     <= '0;
      x      <= initX(pend);
      lineNo <= '0;
      frames <= '0;
    end else if (frameEnd) begin
      live   <= pend;
      fc     <= '0;
      x      <= initX(pend);
      lineNo <= '0;
      frames <= frames + 1'b1;
    end else begin
      fc <= fc + 1'b1;
      if (lineEnd) begin
        x      <= '0;
        lineNo <= lineNo + 1'b1;
      end else begin
        x <= x + 1'b1;
      end
    end
  end

  assign inDispH = (x >= live.dhStart) && (x <= live.dhEnd);
  assign inDispV = (fc >= live.dvStart) && (fc <= live.dvEnd);
  assign inActH  = !live.ahEn || ((x >= live.ahStart) && (x <= live.ahEnd));
  assign inActV  = !live.avEn || ((fc >= live.avStart) && (fc <= live.avEnd));

  always_comb begin
    strobe.run        = run;
    strobe.hsOn       = run && (x < live.hsWidth);
    strobe.vsOn       = run && (fc < live.vsWidth);
    strobe.dispOn     = run && inDispH && inDispV;
    strobe.actOn      = run && inDispH && inDispV && inActH && inActV;
    strobe.frameStart = run && (fc == '0);
  end

  assign pol        = live.pol;
  assign border     = live.border;
  assign uflow      = live.uflow;
  assign lineCount  = cntEn[0] ? lineNo : '0;
  assign frameCount = cntEn[1] ? frames : '0;

  a_r1_x_in_line: assert property (@(posedge clk) disable iff (!rstN)
    (run && live.hPeriod != '0 && live.skew < live.hPeriod) |-> (x < live.hPeriod));

  a_r11_stop_parks: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (fc == '0 && lineNo == '0));

  a_r12_live_hold: assert property (@(posedge clk) disable iff (!rstN)
    (run && !frameEnd) |=> $stable(live));
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  vtg_strobe_t      strobe,
  input  logic [2:0]       pol,
  input  logic [COL_W-1:0] border,
  input  logic [COL_W-1:0] uflow,
  input  logic             pixValid,
  input  logic [COL_W-1:0] pixIn,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [COL_W-1:0] pixOut,
  output logic             vsStart,
  output logic             underrun
);
  logic [COL_W-1:0] colourSel;

  always_comb begin
    if (strobe.actOn)       colourSel = pixValid ? pixIn : uflow;
    else if (strobe.dispOn) colourSel = border;
    else                    colourSel = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      de       <= 1'b0;
      pixOut   <= '0;
      vsStart  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      hsync    <= strobe.hsOn ^ pol[0];
      vsync    <= strobe.vsOn ^ pol[1];
      de       <= strobe.dispOn ^ pol[2];
      pixOut   <= colourSel;
      vsStart  <= strobe.frameStart;
      underrun <= strobe.actOn && !pixValid;
    end
  end

  a_r6_underrun_colour: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (pixOut == $past(uflow)));

  a_r3_de_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (de != $past(pol[2])) |-> $past(strobe.dispOn));
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [31:0]      wrData,
  input  logic             pixValid,
  input  logic [COL_W-1:0] pixIn,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [COL_W-1:0] pixOut,
  output logic             vsStart,
  output logic             underrun,
  output logic [H_W-1:0]   lineCount,
  output logic [FN_W-1:0]  frameCount
);
  vtg_strobe_t      strobe;
  logic [2:0]       pol;
  logic [COL_W-1:0] border, uflow;

  vtg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .pol(pol), .border(border), .uflow(uflow),
    .lineCount(lineCount), .frameCount(frameCount)
  );

  vtg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pol(pol), .border(border),
    .uflow(uflow), .pixValid(pixValid), .pixIn(pixIn), .hsync(hsync),
    .vsync(vsync), .de(de), .pixOut(pixOut), .vsStart(vsStart),
    .underrun(underrun)
  );
endmodule

// File: tb/vid_timing_gen_bench.sv
module vid_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        pixValid = 1'b0;
  logic [23:0] pixIn = '0;
  logic        hsync, vsync, de, vsStart, underrun;
  logic [23:0] pixOut;
  logic [15:0] lineCount, frameCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R11";

  always #2 clk = ~clk;

  vid_timing_gen u_vid_timing_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pixValid(pixValid), .pixIn(pixIn), .hsync(hsync), .vsync(vsync), .de(de),
    .pixOut(pixOut), .vsStart(vsStart), .underrun(underrun),
    .lineCount(lineCount), .frameCount(frameCount)
  );

  // behavioural reference state
  logic [31:0] pReg [0:12];
  logic [31:0] lReg [0:12];
  bit          mRun;
  logic [1:0]  mCnt;
  int          mFc, mX, mLine, mFrames;
  logic        eHs, eVs, eDe, eVss, eUr;
  logic [23:0] ePix;

  function automatic int initPos(logic [31:0] r0, logic [31:0] r11);
    int per = int'(r0[31:16]);
    int sk  = int'(r11[15:0]);
    return (sk == 0) ? 0 : ((per - sk) & 16'hFFFF);
  endfunction

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h at %0t", phase, what, got, exp, $time);
    end
  endtask

  task automatic cycle();
    bit hs, vs, dh, dv, ah, av, disp, act;
    logic [31:0] nP [0:12];
    hs = mRun && (mX < int'(lReg[0][15:0]));
    vs = mRun && (mFc < int'(lReg[2][23:0]));
    dh = (mX >= int'(lReg[3][15:0])) && (mX <= int'(lReg[3][31:16]));
    dv = (mFc >= int'(lReg[4][23:0])) && (mFc <= int'(lReg[5][23:0]));
    ah = !lReg[6][31] || ((mX >= int'(lReg[6][15:0])) && (mX <= int'(lReg[6][30:16])));
    av = !lReg[7][31] || ((mFc >= int'(lReg[7][23:0])) && (mFc <= int'(lReg[8][23:0])));
    disp = mRun && dh && dv;
    act  = disp && ah && av;
    eHs  = hs ^ lReg[12][0];
    eVs  = vs ^ lReg[12][1];
    eDe  = disp ^ lReg[12][2];
    ePix = act ? (pixValid ? pixIn : lReg[10][23:0]) : (disp ? lReg[9][23:0] : 24'h0);
    eVss = mRun && (mFc == 0);
    eUr  = act && !pixValid;
    for (int i = 0; i < 13; i++) nP[i] = pReg[i];
    if (!mRun || mFc == ((int'(lReg[1][23:0]) - 1) & 24'hFFFFFF)) begin
      if (mRun) mFrames = (mFrames + 1) & 16'hFFFF;
      else mFrames = 0;
      for (int i = 0; i < 13; i++) lReg[i] = nP[i];
      mFc = 0;
      mLine = 0;
      mX = initPos(nP[0], nP[11]);
    end else begin
      mFc++;
      if (mX == ((int'(lReg[0][31:16]) - 1) & 16'hFFFF)) begin
        mX = 0;
        mLine = (mLine + 1) & 16'hFFFF;
      end else begin
        mX++;
      end
    end
    if (wrEn) begin
      if (wrAddr < 13) pReg[wrAddr] = wrData;
      else if (wrAddr == 13) mCnt = wrData[1:0];
      else if (wrAddr == 14) mRun = wrData[0];
    end
    @(negedge clk);
    chk("hsync (R1, R7)", 32'(hsync), 32'(eHs));
    chk("vsync (R2, R7)", 32'(vsync), 32'(eVs));
    chk("de (R3, R7)", 32'(de), 32'(eDe));
    chk("pixOut (R5, R6, R8)", 32'(pixOut), 32'(ePix));
    chk("vsStart (R9)", 32'(vsStart), 32'(eVss));
    chk("underrun (R6)", 32'(underrun), 32'(eUr));
    chk("lineCount (R10)", 32'(lineCount), mCnt[0] ? 32'(mLine) : 32'h0);
    chk("frameCount (R10)", 32'(frameCount), mCnt[1] ? 32'(mFrames) : 32'h0);
  endtask

  task automatic wr(int a, logic [31:0] d);
    wrEn = 1'b1;
    wrAddr = 4'(a);
    wrData = d;
    cycle();
    wrEn = 1'b0;
  endtask

  task automatic runFor(int n, int gapEvery);
    for (int i = 0; i < n; i++) begin
      pixIn = 24'($urandom);
      pixValid = (gapEvery == 0) ? 1'b1 : (($urandom % gapEvery) != 0);
      cycle();
    end
  endtask

  initial begin
    for (int i = 0; i < 13; i++) begin pReg[i] = '0; lReg[i] = '0; end
    mRun = 0; mCnt = '0; mFc = 0; mX = 0; mLine = 0; mFrames = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: idle after reset, every output low
    phase = "R11";
    chk("reset hsync (R11)", 32'(hsync), 32'h0);
    chk("reset vsync (R11)", 32'(vsync), 32'h0);
    chk("reset de (R11)", 32'(de), 32'h0);
    chk("reset pixOut (R11)", 32'(pixOut), 32'h0);
    chk("reset vsStart (R9)", 32'(vsStart), 32'h0);
    chk("reset lineCount (R10)", 32'(lineCount), 32'h0);

    phase = "R1";
    wr(0, (32'd12 << 16) | 32'd2);
    wr(1, 32'd96);
    wr(2, 32'd24);
    wr(3, (32'd9 << 16) | 32'd4);
    wr(4, 32'd36);
    wr(5, 32'd83);
    wr(9, 32'h00AA00);
    wr(10, 32'hFF0000);
    wr(13, 32'd3);
    wr(14, 32'd1);
    runFor(250, 7);

    // R12: mid-frame change of sync width and polarity
    phase = "R12";
    wr(0, (32'd12 << 16) | 32'd3);
    wr(12, 32'd1);
    runFor(220, 5);

    // R4 and R5: skew plus an active sub-window with border
    phase = "R5";
    wr(11, 32'd3);
    wr(4, 32'd39);
    wr(5, 32'd86);
    wr(6, 32'h8000_0000 | (32'd7 << 16) | 32'd5);
    wr(7, 32'h8000_0000 | 32'd51);
    wr(8, 32'd74);
    runFor(300, 3);

    phase = "R4";
    wr(6, (32'd7 << 16) | 32'd5);
    wr(12, 32'd6);
    runFor(200, 4);

    // R11: stop with inverted polarity, then restart
    phase = "R11";
    wr(12, 32'd7);
    runFor(10, 0);
    wr(14, 32'd0);
    runFor(20, 0);
    wr(14, 32'd1);
    runFor(200, 6);

    // R10: counter enables
    phase = "R10";
    wr(13, 32'd0);
    runFor(40, 0);
    wr(13, 32'd2);
    runFor(120, 0);
    wr(13, 32'd1);
    runFor(40, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule